// File: doc/BRIEF.md
# Multichannel ADC Scan Sequencer

This block sits on the host side of an external 8-bit successive-approximation converter that has an 8-way input multiplexer and parallel control pins. It walks through the channels enabled in a mask, in ascending order, and repeats the scan for as long as scanning is enabled. For each channel it drives the channel number, strobes the address latch, waits for the selected input to settle, pulses the start line, follows the end-of-conversion line through its fall and its rise, opens the converter's output enable, and takes the 8-bit result once the access time has elapsed. The result leaves with its channel number on a valid/ready port.

Every pin-timing window is a parameter given in nanoseconds. It is turned into system-clock counts by rounding up from the system clock period. The block also makes the converter clock by dividing the system clock. A watchdog drops a channel that never finishes, pulses a timeout output, and lets the scan move on.

Top module: `adc_scan_ctrl`

## Requirements
- R1: `adc_clk` toggles once every DIV_HALF system clocks, where DIV_HALF = ceil(5e8 / ADC_CLK_KHZ / CLK_PERIOD_PS) (half period rounded up, so the clock never runs faster than requested); it is 0 in reset.
- R2: After reset the first channel converted is the lowest channel whose `chan_mask` bit is set. Enabled channels then follow in ascending order and wrap from channel 7 to channel 0. Channels whose bit is clear are skipped. `res_chan` carries the 3-bit channel number (bit i of the mask is channel i).
- R3: `adc_addr` is stable for at least the setup window before `adc_ale` rises and for at least the hold window after it falls; `adc_ale` stays high for at least the latch-pulse window.
- R4: `adc_start` rises no earlier than the settle window after the `adc_ale` rise and stays high for at least the start-pulse window.
- R5: After a start pulse the block waits until `adc_eoc` has been seen low and only then waits for it to rise. A high `adc_eoc` before the fall, up to 8 converter clocks plus the fall window after start, is not taken as completion.
- R6: `adc_oe` is held high for the access window before the data is taken. `res_data` is the value on `adc_data` at the end of that window.
- R7: After `adc_oe` falls, `adc_ale` does not rise again until the release window has passed.
- R8: If `adc_eoc` is not seen low within 8 converter clocks plus the fall window (plus 2 cycles for input synchronisation) of the start rise, `conv_timeout` pulses for one cycle, no result is produced for that channel, and the scan moves on to the next enabled channel.
- R9: If `adc_eoc` has fallen but does not rise within 2 × CONV_CLKS converter clock periods of the start rise, `conv_timeout` pulses once, the channel is dropped and the scan moves on.
- R10: While `res_valid` is high and `res_ready` is low, `res_chan` and `res_data` hold their values and no new channel is started (no `adc_ale` rise).
- R11: In reset, `adc_ale`, `adc_start`, `adc_oe`, `res_valid` and `conv_timeout` are low. With `scan_en` low or `chan_mask` zero, no channel is started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scan_en | input | 1 | Allows new channels to be started |
| chan_mask | input | NCH | Bit i enables channel i in the scan |
| adc_clk | output | 1 | Divided clock for the converter |
| adc_addr | output | CW | Channel number presented to the converter's multiplexer |
| adc_ale | output | 1 | Address-latch strobe |
| adc_start | output | 1 | Start-conversion pulse |
| adc_oe | output | 1 | Converter output enable |
| adc_eoc | input | 1 | End-of-conversion from the converter (asynchronous) |
| adc_data | input | DW | Converter result bus |
| res_valid | output | 1 | Result available |
| res_ready | input | 1 | Consumer accepts result |
| res_chan | output | CW | Channel the result belongs to |
| res_data | output | DW | Conversion result |
| conv_timeout | output | 1 | One-cycle pulse when a channel is dropped |

## Verification
The scan is run with several masks: all channels, with the scan running past channel 7 so that it wraps; the two end channels only; a sparse pattern; a single channel; and an irregular mixed pattern. Each mask is paired with a different end-of-conversion fall delay and either a constant or a gapped ready signal. Comparing the channel order with the mask separates correct skipping and wrap from off-by-one pointer faults. The behavioural converter drives complemented data until the access window has passed and holds its previous result until a new conversion completes. A premature capture, or a late fall of end-of-conversion mistaken for completion, therefore gives a visibly wrong data value. Two stuck-converter cases, one never falling and one never rising, separate the early fall window from the long watchdog. A held-off consumer shows the stall.

// File: rtl/adc_scan_pkg.sv
// adc_scan_pkg: shared state encoding and compile-time helpers for the
// ADC scan sequencer. Assumes all timing parameters are positive integers.
package adc_scan_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ALE,
        ST_HOLD,
        ST_SETTLE,
        ST_START,
        ST_EOC_LO,
        ST_EOC_HI,
        ST_OE,
        ST_REL
    } seq_state_t;

    // Nanoseconds to system clocks, rounded up, never below one.
    function automatic int unsigned ns_to_cyc(int unsigned ns, int unsigned period_ps);
        int unsigned c;
        c = (ns * 1000 + period_ps - 1) / period_ps;
        if (c == 0) c = 1;
        return c;
    endfunction

    // Bits needed to hold the value v.
    function automatic int unsigned bits_for(int unsigned v);
        return (v < 2) ? 1 : $clog2(v + 1);
    endfunction

    function automatic int unsigned umax(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/adc_clk_div.sv
// adc_clk_div: divides the system clock into the converter clock.
// The output toggles every HALF system clocks. Assumes HALF >= 1.
module adc_clk_div
    import adc_scan_pkg::*;
#(
    parameter int unsigned HALF = 79
) (
    input  logic clk,
    input  logic rst_n,
    output logic adc_clk
);
    localparam int unsigned CW = bits_for(HALF - 1);

    logic [CW-1:0] cnt;

    // Count system clocks and flip the converter clock at the end of each half period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            adc_clk <= 1'b0;
        end else if (cnt == CW'(HALF - 1)) begin
            cnt     <= '0;
            adc_clk <= ~adc_clk;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // R1: the clock only changes after a full half period has been counted.
    assert_div_toggle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (adc_clk != $past(adc_clk)) |-> (cnt == '0))
        else $error("converter clock toggled mid half-period");

endmodule

// File: rtl/adc_chan_pick.sv
// adc_chan_pick: finds the first enabled channel at or after a start pointer,
// wrapping past the highest channel. Purely combinational.
// Assumes ptr < NCH.
module adc_chan_pick #(
    parameter int unsigned NCH = 8,
    parameter int unsigned CW  = 3
) (
    input  logic [NCH-1:0] mask,
    input  logic [CW-1:0]  ptr,
    output logic           found,
    output logic [CW-1:0]  sel
);
    // Walk the offsets from far to near so the nearest enabled channel wins.
    always_comb begin
        found = 1'b0;
        sel   = '0;
        for (int k = NCH - 1; k >= 0; k--) begin
            int idx;
            idx = (int'(ptr) + k) % NCH;
            if (mask[idx]) begin
                found = 1'b1;
                sel   = CW'(idx);
            end
        end
    end

endmodule

// File: rtl/adc_result_slot.sv
// adc_result_slot: a single-entry output register on a valid/ready port.
// Assumes load is only raised while the slot is empty.
module adc_result_slot #(
    parameter int unsigned CW = 3,
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] ld_chan,
    input  logic [DW-1:0] ld_data,
    output logic          busy,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [CW-1:0] out_chan,
    output logic [DW-1:0] out_data
);
    // Fill on load, empty on handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_chan  <= '0;
            out_data  <= '0;
        end else if (load) begin
            out_valid <= 1'b1;
            out_chan  <= ld_chan;
            out_data  <= ld_data;
        end else if (out_valid && out_ready) begin
            out_valid <= 1'b0;
        end
    end

    assign busy = out_valid;

    // R10: an offered result stays put until it is taken.
    assert_hold_result_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_chan) && $stable(out_data)))
        else $error("result changed while stalled");

    // R10: the sequencer never loads over an unread result.
    assert_no_overwrite_R10: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> !out_valid)
        else $error("result slot overwritten");

endmodule

// File: rtl/adc_scan_fsm.sv
// adc_scan_fsm: drives the converter pins for one channel at a time.
// It presents the address, strobes the latch, waits for the input to settle,
// pulses start, follows end-of-conversion low and then high, opens the output
// and captures the result. All windows are in system clocks and are >= 1.
// Assumes T_EOCF < T_WDOG and that adc_data is stable once the access window ends.
module adc_scan_fsm
    import adc_scan_pkg::*;
#(
    parameter int unsigned NCH      = 8,
    parameter int unsigned CW       = 3,
    parameter int unsigned DW       = 8,
    parameter int unsigned T_SU     = 5,
    parameter int unsigned T_ALE    = 20,
    parameter int unsigned T_HD     = 5,
    parameter int unsigned T_SETTLE = 250,
    parameter int unsigned T_START  = 20,
    parameter int unsigned T_OEA    = 25,
    parameter int unsigned T_OER    = 25,
    parameter int unsigned T_EOCF   = 1466,
    parameter int unsigned T_WDOG   = 20224
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scan_en,
    input  logic          pick_found,
    input  logic [CW-1:0] pick_sel,
    output logic [CW-1:0] ptr,
    input  logic          slot_busy,
    input  logic          eoc_raw,
    input  logic [DW-1:0] adc_data,
    output logic [CW-1:0] adc_addr,
    output logic          adc_ale,
    output logic          adc_start,
    output logic          adc_oe,
    output logic          push,
    output logic [CW-1:0] push_chan,
    output logic [DW-1:0] push_data,
    output logic          conv_timeout
);
    localparam int unsigned TMAX = umax(umax(umax(T_SU, T_ALE), umax(T_HD, T_SETTLE)),
                                        umax(T_START, umax(T_OEA, T_OER)));
    localparam int unsigned TW   = bits_for(TMAX);
    localparam int unsigned WW   = bits_for(T_WDOG);

    seq_state_t    state;
    logic [TW-1:0] tmr;
    logic [WW-1:0] wcnt;
    logic          lo_seen;
    logic [1:0]    eoc_sync;
    logic          eoc_s;

    // Bring the asynchronous end-of-conversion pin into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) eoc_sync <= 2'b11;
        else        eoc_sync <= {eoc_sync[0], eoc_raw};
    end
    assign eoc_s = eoc_sync[1];

    // Phase sequencing, pin drive, capture and timeout handling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state        <= ST_IDLE;
            tmr          <= '0;
            wcnt         <= '0;
            lo_seen      <= 1'b0;
            ptr          <= '0;
            adc_addr     <= '0;
            adc_ale      <= 1'b0;
            adc_start    <= 1'b0;
            adc_oe       <= 1'b0;
            push         <= 1'b0;
            push_chan    <= '0;
            push_data    <= '0;
            conv_timeout <= 1'b0;
        end else begin
            push         <= 1'b0;
            conv_timeout <= 1'b0;
            if (tmr != '0) tmr <= tmr - 1'b1;
            if (wcnt != WW'(T_WDOG)) wcnt <= wcnt + 1'b1;
            case (state)
                ST_IDLE: begin
                    if (scan_en && pick_found && !slot_busy) begin
                        adc_addr <= pick_sel;
                        tmr      <= TW'(T_SU - 1);
                        state    <= ST_ADDR;
                    end
                end
                ST_ADDR: begin
                    if (tmr == '0) begin
                        adc_ale <= 1'b1;
                        tmr     <= TW'(T_ALE - 1);
                        state   <= ST_ALE;
                    end
                end
                ST_ALE: begin
                    if (tmr == '0) begin
                        adc_ale <= 1'b0;
                        tmr     <= TW'(T_HD - 1);
                        state   <= ST_HOLD;
                    end
                end
                ST_HOLD: begin
                    if (tmr == '0) begin
                        tmr   <= TW'(T_SETTLE - 1);
                        state <= ST_SETTLE;
                    end
                end
                ST_SETTLE: begin
                    if (tmr == '0) begin
                        adc_start <= 1'b1;
                        tmr       <= TW'(T_START - 1);
                        wcnt      <= '0;
                        lo_seen   <= 1'b0;
                        state     <= ST_START;
                    end
                end
                ST_START: begin
                    if (!eoc_s) lo_seen <= 1'b1;
                    if (tmr == '0) begin
                        adc_start <= 1'b0;
                        state     <= ST_EOC_LO;
                    end
                end
                ST_EOC_LO: begin
                    if (!eoc_s || lo_seen) begin
                        state <= ST_EOC_HI;
                    end else if (wcnt >= WW'(T_EOCF)) begin
                        conv_timeout <= 1'b1;
                        ptr          <= CW'((int'(adc_addr) + 1) % NCH);
                        state        <= ST_IDLE;
                    end
                end
                ST_EOC_HI: begin
                    if (eoc_s) begin
                        adc_oe <= 1'b1;
                        tmr    <= TW'(T_OEA - 1);
                        state  <= ST_OE;
                    end else if (wcnt >= WW'(T_WDOG)) begin
                        conv_timeout <= 1'b1;
                        ptr          <= CW'((int'(adc_addr) + 1) % NCH);
                        state        <= ST_IDLE;
                    end
                end
                ST_OE: begin
                    if (tmr == '0) begin
                        push      <= 1'b1;
                        push_chan <= adc_addr;
                        push_data <= adc_data;
                        adc_oe    <= 1'b0;
                        tmr       <= TW'(T_OER - 1);
                        state     <= ST_REL;
                    end
                end
                ST_REL: begin
                    if (tmr == '0) begin
                        ptr   <= CW'((int'(adc_addr) + 1) % NCH);
                        state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R3: the latched address does not move while the strobe is high.
    assert_addr_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        adc_ale |-> $stable(adc_addr))
        else $error("address moved under latch strobe");

    // R6: output enable never overlaps the latch or start strobes.
    assert_oe_alone_R6: assert property (@(posedge clk) disable iff (!rst_n)
        adc_oe |-> (!adc_ale && !adc_start))
        else $error("output enable overlaps a strobe");

    // R5: output enable opens only after end-of-conversion has come back high.
    assert_oe_after_eoc_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(adc_oe) |-> eoc_s)
        else $error("output enabled before conversion end");

    // R8: a timeout is a single-cycle pulse.
    assert_tmo_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        conv_timeout |=> !conv_timeout)
        else $error("timeout pulse longer than one cycle");

    // R10: no channel is launched while an unread result is held.
    assert_no_launch_full_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(adc_ale) |-> !slot_busy)
        else $error("channel launched with result pending");

endmodule

// File: rtl/adc_scan_ctrl.sv
// adc_scan_ctrl: top of the host-side scan sequencer for an external 8-bit
// multiplexed successive-approximation converter. Converts nanosecond windows
// into system clocks (rounded up) and wires the divider, channel picker,
// pin sequencer and result slot together.
// Assumes NCH channels selectable by a CW-bit address and a DW-bit result.
module adc_scan_ctrl
    import adc_scan_pkg::*;
#(
    parameter int unsigned NCH            = 8,
    parameter int unsigned DW             = 8,
    parameter int unsigned CLK_PERIOD_PS  = 10000,
    parameter int unsigned ADC_CLK_KHZ    = 640,
    parameter int unsigned CONV_CLKS      = 64,
    parameter int unsigned T_SU_NS        = 50,
    parameter int unsigned T_HD_NS        = 50,
    parameter int unsigned T_ALE_NS       = 200,
    parameter int unsigned T_START_NS     = 200,
    parameter int unsigned T_SETTLE_NS    = 2500,
    parameter int unsigned T_OE_ACC_NS    = 250,
    parameter int unsigned T_OE_REL_NS    = 250,
    parameter int unsigned EOC_FALL_CLKS  = 8,
    parameter int unsigned EOC_FALL_NS    = 2000,
    localparam int unsigned CW            = bits_for(NCH - 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           scan_en,
    input  logic [NCH-1:0] chan_mask,
    output logic           adc_clk,
    output logic [CW-1:0]  adc_addr,
    output logic           adc_ale,
    output logic           adc_start,
    output logic           adc_oe,
    input  logic           adc_eoc,
    input  logic [DW-1:0]  adc_data,
    output logic           res_valid,
    input  logic           res_ready,
    output logic [CW-1:0]  res_chan,
    output logic [DW-1:0]  res_data,
    output logic           conv_timeout
);
    localparam int unsigned SYNC_LAT = 2;
    localparam int unsigned HALF_PS  = 500000000 / ADC_CLK_KHZ;
    localparam int unsigned DIV_HALF = (HALF_PS + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS;
    localparam int unsigned T_SU     = ns_to_cyc(T_SU_NS, CLK_PERIOD_PS);
    localparam int unsigned T_HD     = ns_to_cyc(T_HD_NS, CLK_PERIOD_PS);
    localparam int unsigned T_ALE    = ns_to_cyc(T_ALE_NS, CLK_PERIOD_PS);
    localparam int unsigned T_START  = ns_to_cyc(T_START_NS, CLK_PERIOD_PS);
    localparam int unsigned T_SETTLE = ns_to_cyc(T_SETTLE_NS, CLK_PERIOD_PS);
    localparam int unsigned T_OEA    = ns_to_cyc(T_OE_ACC_NS, CLK_PERIOD_PS);
    localparam int unsigned T_OER    = ns_to_cyc(T_OE_REL_NS, CLK_PERIOD_PS);
    localparam int unsigned T_EOCF   = EOC_FALL_CLKS * 2 * DIV_HALF
                                       + ns_to_cyc(EOC_FALL_NS, CLK_PERIOD_PS) + SYNC_LAT;
    localparam int unsigned T_WDOG   = 2 * CONV_CLKS * 2 * DIV_HALF;

    logic          pick_found;
    logic [CW-1:0] pick_sel;
    logic [CW-1:0] ptr;
    logic          slot_busy;
    logic          push;
    logic [CW-1:0] push_chan;
    logic [DW-1:0] push_data;

    adc_clk_div #(.HALF(DIV_HALF)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .adc_clk (adc_clk)
    );

    adc_chan_pick #(.NCH(NCH), .CW(CW)) u_pick (
        .mask  (chan_mask),
        .ptr   (ptr),
        .found (pick_found),
        .sel   (pick_sel)
    );

    adc_scan_fsm #(
        .NCH(NCH), .CW(CW), .DW(DW),
        .T_SU(T_SU), .T_ALE(T_ALE), .T_HD(T_HD), .T_SETTLE(T_SETTLE),
        .T_START(T_START), .T_OEA(T_OEA), .T_OER(T_OER),
        .T_EOCF(T_EOCF), .T_WDOG(T_WDOG)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .scan_en      (scan_en),
        .pick_found   (pick_found),
        .pick_sel     (pick_sel),
        .ptr          (ptr),
        .slot_busy    (slot_busy),
        .eoc_raw      (adc_eoc),
        .adc_data     (adc_data),
        .adc_addr     (adc_addr),
        .adc_ale      (adc_ale),
        .adc_start    (adc_start),
        .adc_oe       (adc_oe),
        .push         (push),
        .push_chan    (push_chan),
        .push_data    (push_data),
        .conv_timeout (conv_timeout)
    );

    adc_result_slot #(.CW(CW), .DW(DW)) u_slot (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (push),
        .ld_chan   (push_chan),
        .ld_data   (push_data),
        .busy      (slot_busy),
        .out_valid (res_valid),
        .out_ready (res_ready),
        .out_chan  (res_chan),
        .out_data  (res_data)
    );

endmodule

// File: tb/sim_adc_scan_ctrl.sv
// sim_adc_scan_ctrl: bench with a behavioural converter model, a table of
// scan patterns walked by one loop, then directed reset, stall and timeout tests.
module sim_adc_scan_ctrl;

    // Expected windows in system clocks for the parameters used below (10 ns clock).
    localparam int P_HALF   = 5;       // R1: ceil(5e8/10000 kHz / 10000 ps)
    localparam int SU       = 5;
    localparam int HD       = 5;
    localparam int ALE_W    = 20;
    localparam int ST_W     = 20;
    localparam int SETTLE   = 250;
    localparam int OEA      = 25;
    localparam int OER      = 25;
    localparam int EOCF     = 8 * 2 * P_HALF + 200 + 2;
    localparam int WDOG     = 2 * 64 * 2 * P_HALF;
    localparam int CONV_LEN = 40;

    // Row: mask[29:22] seed[21:14] nres[13:6] fall_dly[5:2] ready_mode[1:0]
    localparam logic [29:0] ROWS [5] = '{
        {8'hFF, 8'h10, 8'd10, 4'd0, 2'd0},
        {8'h81, 8'h5A, 8'd5,  4'd8, 2'd1},
        {8'h24, 8'hC3, 8'd4,  4'd3, 2'd0},
        {8'h01, 8'h77, 8'd3,  4'd8, 2'd1},
        {8'h9A, 8'h3C, 8'd6,  4'd1, 2'd0}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scan_en = 1'b0;
    logic [7:0] chan_mask = 8'h00;
    logic       adc_clk;
    logic [2:0] adc_addr;
    logic       adc_ale, adc_start, adc_oe;
    logic       adc_eoc;
    logic [7:0] adc_data;
    logic       res_valid;
    logic       rdy;
    logic [2:0] res_chan;
    logic [7:0] res_data;
    logic       conv_timeout;

    always #5 clk = ~clk;

    adc_scan_ctrl #(.ADC_CLK_KHZ(10000)) u0 (
        .clk(clk), .rst_n(rst_n), .scan_en(scan_en), .chan_mask(chan_mask),
        .adc_clk(adc_clk), .adc_addr(adc_addr), .adc_ale(adc_ale),
        .adc_start(adc_start), .adc_oe(adc_oe), .adc_eoc(adc_eoc),
        .adc_data(adc_data), .res_valid(res_valid), .res_ready(rdy),
        .res_chan(res_chan), .res_data(res_data), .conv_timeout(conv_timeout)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;
    int cyc   = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] val(input logic [2:0] ch, input logic [7:0] seed);
        return seed + 8'(ch) * 8'd29 + 8'd7;
    endfunction

    // k-th channel (from 0) of a scan started after reset.
    function automatic int exp_chan(input logic [7:0] m, input int k);
        int seen = 0;
        for (int i = 0; i < 8 * 64; i++) begin
            if (m[i % 8]) begin
                if (seen == k) return i % 8;
                seen++;
            end
        end
        return -1;
    endfunction

    // ---------------- behavioural converter ----------------
    logic [7:0] seed = 8'h00;
    int         fall_dly = 0;
    int         stuck_kind = 0;   // 0 none, 1 eoc never falls, 2 never rises
    logic [2:0] stuck_ch = 3'd0;
    logic [2:0] lat_ch;
    logic [7:0] res_reg;
    logic       eoc_m, ck_p, ale_p, st_p;
    int         ph, fcnt, ccnt, oe_cnt;

    always @(negedge clk) begin
        if (!rst_n) begin
            eoc_m = 1; res_reg = 0; ph = 0; fcnt = 0; ccnt = 0; oe_cnt = 0;
            lat_ch = 0; ck_p = 0; ale_p = 0; st_p = 0;
        end else begin
            bit stuck;
            bit ck_rise;
            ck_rise = adc_clk && !ck_p;
            if (adc_ale && !ale_p) lat_ch = adc_addr;
            stuck = (stuck_kind != 0) && (lat_ch == stuck_ch);
            if (adc_start && !st_p) begin
                ph = 1; fcnt = 0; eoc_m = 1;
                if (fall_dly == 0 && !(stuck && stuck_kind == 1)) eoc_m = 0;
            end else if (ph != 0 && eoc_m && ck_rise && !(stuck && stuck_kind == 1)) begin
                fcnt++;
                if (fcnt >= fall_dly) eoc_m = 0;
            end
            if (!adc_start && st_p && ph == 1) begin ph = 2; ccnt = 0; end
            if (ph == 2 && ck_rise) ccnt++;
            if (ph == 2 && ccnt >= CONV_LEN && !eoc_m && !stuck) begin
                res_reg = val(lat_ch, seed); eoc_m = 1; ph = 0;
            end
            if (adc_oe) oe_cnt++; else oe_cnt = 0;
            ck_p = adc_clk; ale_p = adc_ale; st_p = adc_start;
        end
        adc_eoc  = eoc_m;
        adc_data = (adc_oe && oe_cnt >= OEA) ? res_reg : ~res_reg;
    end

    // ---------------- consumer and pin-timing monitor ----------------
    int         rmode = 0;
    int         got_n = 0;
    int         got_ch [64];
    int         got_dt [64];
    int         ale_rises = 0, tmo_n = 0, tmo_dly = -1;
    int         min_ale = 99999, min_su = 99999, min_st = 99999, min_settle = 99999;
    int         min_rel = 99999, hold_viol = 0, hp_min = 99999, hp_max = 0, hp_seen = 0;
    int         ale_len, st_len, addr_age, since_ale, since_st, since_oe, hold_cnt, ck_age;
    bit         hold_watch, oe_fell, m_ale_p, m_st_p, m_oe_p, m_ck_p;
    logic [2:0] m_addr_p;

    always @(negedge clk) begin
        cyc++;
        if (!rst_n) begin
            rdy = 0;
            ale_len = 0; st_len = 0; addr_age = 0; since_ale = 0; since_st = 0;
            since_oe = 0; hold_cnt = 0; hold_watch = 0; oe_fell = 0; ck_age = 0; hp_seen = 0;
            m_ale_p = 0; m_st_p = 0; m_oe_p = 0; m_ck_p = 0; m_addr_p = adc_addr;
        end else begin
            rdy = (rmode == 0) ? 1'b1 : (rmode == 1) ? (cyc % 3 != 0) : 1'b0;
            if (res_valid && rdy && got_n < 64) begin
                got_ch[got_n] = res_chan; got_dt[got_n] = res_data; got_n++;
            end
            // address age and hold window
            if (adc_addr != m_addr_p) begin
                if (hold_watch && hold_cnt < HD) hold_viol++;
                addr_age = 0;
            end else addr_age++;
            if (hold_watch) begin hold_cnt++; if (hold_cnt >= HD) hold_watch = 0; end
            since_ale++; since_st++; since_oe++;
            if (adc_ale && !m_ale_p) begin
                ale_rises++;
                if (addr_age < min_su) min_su = addr_age;
                if (oe_fell && since_oe < min_rel) min_rel = since_oe;
                since_ale = 0; ale_len = 0;
            end
            if (adc_ale) ale_len++;
            if (!adc_ale && m_ale_p) begin
                if (ale_len < min_ale) min_ale = ale_len;
                hold_watch = 1; hold_cnt = 0;
            end
            if (adc_start && !m_st_p) begin
                if (since_ale < min_settle) min_settle = since_ale;
                since_st = 0; st_len = 0;
            end
            if (adc_start) st_len++;
            if (!adc_start && m_st_p && st_len < min_st) min_st = st_len;
            if (!adc_oe && m_oe_p) begin oe_fell = 1; since_oe = 0; end
            if (conv_timeout) begin
                tmo_n++;
                if (tmo_dly < 0) tmo_dly = since_st;
            end
            // converter clock half periods
            if (adc_clk != m_ck_p) begin
                if (hp_seen >= 1) begin
                    if (ck_age < hp_min) hp_min = ck_age;
                    if (ck_age > hp_max) hp_max = ck_age;
                end
                hp_seen++; ck_age = 1;
            end else ck_age++;
            m_ale_p = adc_ale; m_st_p = adc_start; m_oe_p = adc_oe; m_ck_p = adc_clk;
            m_addr_p = adc_addr;
        end
    end

    task automatic report_and_end();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    // Watchdog: a hung run is a failed check.
    always @(negedge clk) begin
        if (cyc >= 190000 && !done) begin
            chk(0, "watchdog expired", cyc, 190000);
            report_and_end();
        end
    end

    task automatic do_reset();
        rst_n = 0; scan_en = 0;
        got_n = 0; tmo_n = 0; tmo_dly = -1; ale_rises = 0;
        repeat (4) @(negedge clk);
        rst_n = 1;
    endtask

    task automatic wait_results(input int n, input int limit);
        int t = 0;
        while (got_n < n && t < limit) begin @(negedge clk); t++; end
        chk(got_n >= n, "result count (scan progress)", got_n, n);
    endtask

    initial begin
        // ---- reset state (R11, R1) ----
        rst_n = 0;
        repeat (3) @(negedge clk);
        chk(adc_ale == 0,      "R11 ale in reset", adc_ale, 0);
        chk(adc_start == 0,    "R11 start in reset", adc_start, 0);
        chk(adc_oe == 0,       "R11 oe in reset", adc_oe, 0);
        chk(res_valid == 0,    "R11 res_valid in reset", res_valid, 0);
        chk(conv_timeout == 0, "R11 timeout in reset", conv_timeout, 0);
        chk(adc_clk == 0,      "R1 adc_clk in reset", adc_clk, 0);

        // ---- table of scan patterns (R2, R5, R6) ----
        for (int r = 0; r < 5; r++) begin
            logic [7:0] m;
            int nres;
            m        = ROWS[r][29:22];
            seed     = ROWS[r][21:14];
            nres     = int'(ROWS[r][13:6]);
            fall_dly = int'(ROWS[r][5:2]);
            rmode    = int'(ROWS[r][1:0]);
            stuck_kind = 0;
            chan_mask = m;
            do_reset();
            scan_en = 1;
            wait_results(nres, 20000);
            scan_en = 0;
            for (int k = 0; k < nres; k++) begin
                int ec;
                ec = exp_chan(m, k);
                chk(got_ch[k] == ec, $sformatf("R2 row %0d channel order k=%0d", r, k), got_ch[k], ec);
                chk(got_dt[k] == int'(val(3'(ec), seed)),
                    $sformatf("R6/R5 row %0d data k=%0d", r, k), got_dt[k], int'(val(3'(ec), seed)));
            end
            repeat (1000) @(negedge clk);
        end

        // ---- pin timing gathered over the table (R1, R3, R4, R7) ----
        chk(hp_min == P_HALF && hp_max == P_HALF, "R1 converter half period", hp_min, P_HALF);
        chk(hp_max == P_HALF, "R1 converter half period max", hp_max, P_HALF);
        chk(min_su >= SU, "R3 address setup", min_su, SU);
        chk(hold_viol == 0, "R3 address hold", hold_viol, 0);
        chk(min_ale >= ALE_W, "R3 latch pulse width", min_ale, ALE_W);
        chk(min_settle >= SETTLE, "R4 settle before start", min_settle, SETTLE);
        chk(min_st >= ST_W, "R4 start pulse width", min_st, ST_W);
        chk(min_rel >= OER, "R7 release before next latch", min_rel, OER);

        // ---- stall (R10) ----
        seed = 8'h42; fall_dly = 2; stuck_kind = 0; rmode = 2; chan_mask = 8'h06;
        do_reset();
        scan_en = 1;
        repeat (3000) @(negedge clk);
        chk(res_valid == 1, "R10 result offered while stalled", res_valid, 1);
        chk(res_chan == 3'd1, "R10 stalled channel", res_chan, 1);
        chk(res_data == val(3'd1, 8'h42), "R10 stalled data", res_data, val(3'd1, 8'h42));
        chk(ale_rises == 1, "R10 no new channel while stalled", ale_rises, 1);
        repeat (500) @(negedge clk);
        chk(res_data == val(3'd1, 8'h42), "R10 data held", res_data, val(3'd1, 8'h42));
        rmode = 0;
        wait_results(2, 5000);
        chk(got_ch[1] == 2, "R10 scan resumes after stall", got_ch[1], 2);
        scan_en = 0;

        // ---- idle conditions (R11) ----
        rmode = 0; chan_mask = 8'h00;
        do_reset();
        scan_en = 1;
        repeat (2000) @(negedge clk);
        chk(ale_rises == 0, "R11 empty mask starts nothing", ale_rises, 0);
        scan_en = 0; chan_mask = 8'hFF;
        repeat (500) @(negedge clk);
        chk(ale_rises == 0, "R11 disabled scan starts nothing", ale_rises, 0);

        // ---- end-of-conversion never falls (R8) ----
        seed = 8'h21; fall_dly = 1; stuck_kind = 1; stuck_ch = 3'd0; chan_mask = 8'h05;
        do_reset();
        scan_en = 1;
        wait_results(2, 20000);
        scan_en = 0;
        chk(tmo_n >= 1, "R8 timeout pulsed", tmo_n, 1);
        chk(tmo_dly >= EOCF && tmo_dly <= EOCF + 3, "R8 fall window length", tmo_dly, EOCF);
        chk(got_ch[0] == 2 && got_ch[1] == 2, "R8 dropped channel skipped", got_ch[0], 2);
        chk(got_dt[0] == int'(val(3'd2, 8'h21)), "R8 next channel data", got_dt[0], int'(val(3'd2, 8'h21)));

        // ---- end-of-conversion never rises (R9) ----
        seed = 8'h63; stuck_kind = 2; stuck_ch = 3'd0; chan_mask = 8'h05;
        do_reset();
        scan_en = 1;
        wait_results(2, 20000);
        scan_en = 0;
        chk(tmo_n >= 1, "R9 timeout pulsed", tmo_n, 1);
        chk(tmo_dly >= WDOG && tmo_dly <= WDOG + 3, "R9 watchdog length", tmo_dly, WDOG);
        chk(got_ch[0] == 2 && got_ch[1] == 2, "R9 dropped channel skipped", got_ch[1], 2);
        stuck_kind = 0;

        report_and_end();
    end

endmodule